// File: doc/BRIEF.md
# Incremental Duty-Cycle Update Unit

This block is the digital front and back end of an incremental, surface-based controller for a switching regulator. Once per sampling tick it takes the sampled output-voltage code and the setpoint code, forms the signed error (output minus setpoint) and the change of that error since the previous tick, and presents both to an external control-surface evaluator. The evaluator returns a signed duty-cycle increment. On the same tick the block scales that increment by a programmable gain and adds it to the stored duty cycle.

The unit is incremental. The surface output moves the duty cycle and does not set it outright, and the previous error is kept internally so that the change of error can be formed. The increment that is present on a tick is the evaluator's answer to the error pair from the previous tick. This gives a one-sample loop delay, and that delay is the designer's to budget. The accumulated duty cycle is an unsigned code that saturates at both ends and can feed a PWM comparator directly. All state moves only on the sample strobe, with one clock of latency. The strobe rate needs only to keep up with a switching frequency near 100 kHz, which leaves hundreds of clocks between ticks.

Top module: `duty_incr_unit`

## Requirements
- R1: While rst_ni is low, err_o, derr_o and duty_o are all zero, and the stored previous error is zero.
- R2: On a cycle with sample_i high, err_o takes the two's-complement value vo_code_i − ref_code_i (both inputs unsigned, result VW+1 bits signed). The value is visible on the clock edge that samples the strobe, one cycle of latency.
- R3: On the same edge, derr_o takes the new error minus the error from the previous sample (VW+2 bits signed). The first sample after reset therefore yields derr_o equal to err_o.
- R4: While sample_i is low, err_o, derr_o and duty_o hold their values.
- R5: On a sample, the step is floor(incr_i × gain_i / 2^GFRAC). Here incr_i is signed two's complement and gain_i is unsigned with GFRAC fractional bits (default 4, so 16 is unity gain). duty_o becomes the old duty plus this step, one cycle after the strobe.
- R6: If the sum exceeds 2^DW − 1, duty_o becomes exactly 2^DW − 1. It never wraps to a small value.
- R7: If the sum is negative, duty_o becomes 0. It never wraps to a large value.
- R8: A gain of zero leaves duty_o unchanged on a sample, whatever the increment. The error outputs still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | One-cycle sampling strobe |
| vo_code_i | input | VW | Sampled output-voltage code, unsigned |
| ref_code_i | input | VW | Setpoint code, unsigned |
| incr_i | input | DIW | Surface-evaluator increment, signed |
| gain_i | input | GW | Gain, unsigned, GFRAC fractional bits |
| err_o | output | VW+1 | Error, signed |
| derr_o | output | VW+2 | Change of error, signed |
| duty_o | output | DW | Accumulated duty cycle, unsigned |

## Verification
The bench drives full-scale codes in both directions, which produces the largest error and a change of error of nearly twice full scale. A design that sized or sign-extended these narrowly would show wrapped, sign-flipped values. It pushes the duty cycle past both rails with the largest products. A non-saturating adder would wrap to the far rail, and a clamp placed after truncation would clamp the wrong value. It applies a fractional gain to a negative increment, where truncation toward zero and floor give different results. It also checks zero gain, idle holding, and a reset in the middle of a run that must clear the stored previous error, so that the first change of error equals the error again.

// File: rtl/duty_pkg.sv
package duty_pkg;
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/err_stage.sv
module err_stage #(
  parameter int VW = 12,
  localparam int EW = VW + 1,
  localparam int CW = VW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic [VW-1:0]        vo_i,
  input  logic [VW-1:0]        ref_i,
  output logic signed [EW-1:0] err_o,
  output logic signed [CW-1:0] derr_o
);
  logic signed [EW-1:0] err_d, err_q;
  logic signed [CW-1:0] derr_d, derr_q;

  always_comb begin
    err_d  = $signed({1'b0, vo_i}) - $signed({1'b0, ref_i});
    // err_q still holds e(k-1) here
    derr_d = $signed({err_d[EW-1], err_d}) - $signed({err_q[EW-1], err_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      derr_q <= '0;
    end else if (sample_i) begin
      err_q  <= err_d;
      derr_q <= derr_d;
    end
  end

  assign err_o  = err_q;
  assign derr_o = derr_q;
endmodule

// File: rtl/gain_scale.sv
module gain_scale #(
  parameter int DIW   = 10,
  parameter int GW    = 8,
  parameter int GFRAC = 4,
  localparam int PW   = DIW + GW + 1
) (
  input  logic signed [DIW-1:0] incr_i,
  input  logic [GW-1:0]         gain_i,
  output logic signed [PW-1:0]  step_o
);
  logic signed [PW-1:0] inc_x, gain_x, prod;

  always_comb begin
    inc_x  = $signed({{(GW+1){incr_i[DIW-1]}}, incr_i});
    gain_x = $signed({{(DIW+1){1'b0}}, gain_i});
    prod   = inc_x * gain_x;
    // arithmetic shift: floor toward minus infinity
    step_o = prod >>> GFRAC;
  end
endmodule

// File: rtl/duty_accum.sv
module duty_accum #(
  parameter int DW = 12,
  parameter int PW = 19,
  localparam int SW = duty_pkg::max2(PW, DW + 1) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic signed [PW-1:0] step_i,
  output logic [DW-1:0]        duty_o
);
  localparam logic signed [SW-1:0] FULL = $signed({{(SW-DW){1'b0}}, {DW{1'b1}}});

  logic [DW-1:0]        duty_q, duty_d;
  logic signed [SW-1:0] sum;

  always_comb begin
    sum = $signed({{(SW-DW){1'b0}}, duty_q}) + $signed({{(SW-PW){step_i[PW-1]}}, step_i});
    if (sum[SW-1])       duty_d = '0;
    else if (sum > FULL) duty_d = {DW{1'b1}};
    else                 duty_d = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       duty_q <= '0;
    else if (sample_i) duty_q <= duty_d;
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/duty_incr_unit.sv
module duty_incr_unit #(
  parameter int VW    = 12,
  parameter int DIW   = 10,
  parameter int GW    = 8,
  parameter int GFRAC = 4,
  parameter int DW    = 12,
  localparam int EW   = VW + 1,
  localparam int CW   = VW + 2,
  localparam int PW   = DIW + GW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sample_i,
  input  logic [VW-1:0]         vo_code_i,
  input  logic [VW-1:0]         ref_code_i,
  input  logic signed [DIW-1:0] incr_i,
  input  logic [GW-1:0]         gain_i,
  output logic signed [EW-1:0]  err_o,
  output logic signed [CW-1:0]  derr_o,
  output logic [DW-1:0]         duty_o
);
  logic signed [PW-1:0] step;

  err_stage #(.VW(VW)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .vo_i     (vo_code_i),
    .ref_i    (ref_code_i),
    .err_o    (err_o),
    .derr_o   (derr_o)
  );

  gain_scale #(.DIW(DIW), .GW(GW), .GFRAC(GFRAC)) u_gain (
    .incr_i (incr_i),
    .gain_i (gain_i),
    .step_o (step)
  );

  duty_accum #(.DW(DW), .PW(PW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .step_i   (step),
    .duty_o   (duty_o)
  );
endmodule

// File: rtl/duty_incr_chk.sv
module duty_incr_chk #(
  parameter int VW  = 12,
  parameter int DIW = 10,
  parameter int GW  = 8,
  parameter int DW  = 12,
  localparam int EW = VW + 1,
  localparam int CW = VW + 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sample_i,
  input logic [VW-1:0]         vo_code_i,
  input logic [VW-1:0]         ref_code_i,
  input logic signed [DIW-1:0] incr_i,
  input logic [GW-1:0]         gain_i,
  input logic signed [EW-1:0]  err_o,
  input logic signed [CW-1:0]  derr_o,
  input logic [DW-1:0]         duty_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (err_o == '0 && derr_o == '0 && duty_o == '0);
    end
  end

  assert_err_diff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sample_i) |-> err_o == ($signed({1'b0, $past(vo_code_i)}) - $signed({1'b0, $past(ref_code_i)})));

  assert_derr_delta_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sample_i) |-> $signed(derr_o) == ($signed(err_o) - $signed($past(err_o))));

  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_i) |-> ($stable(err_o) && $stable(derr_o) && $stable(duty_o)));

  assert_no_wrap_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i) && !$past(incr_i[DIW-1])) |-> duty_o >= $past(duty_o));

  assert_no_wrap_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i) && $past(incr_i[DIW-1])) |-> duty_o <= $past(duty_o));

  assert_zero_gain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i) && $past(gain_i) == '0) |-> duty_o == $past(duty_o));
endmodule

bind duty_incr_unit duty_incr_chk #(.VW(VW), .DIW(DIW), .GW(GW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .vo_code_i  (vo_code_i),
  .ref_code_i (ref_code_i),
  .incr_i     (incr_i),
  .gain_i     (gain_i),
  .err_o      (err_o),
  .derr_o     (derr_o),
  .duty_o     (duty_o)
);

// File: tb/tb_duty_incr_unit.sv
module tb_duty_incr_unit;
  localparam int VW = 12, DIW = 10, GW = 8, GFRAC = 4, DW = 12;
  localparam int FULL = (1 << DW) - 1;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  sample_i = 1'b0;
  logic [VW-1:0]         vo_code_i = '0;
  logic [VW-1:0]         ref_code_i = '0;
  logic signed [DIW-1:0] incr_i = '0;
  logic [GW-1:0]         gain_i = '0;
  logic signed [VW:0]    err_o;
  logic signed [VW+1:0]  derr_o;
  logic [DW-1:0]         duty_o;

  always #5 clk = ~clk;

  duty_incr_unit #(.VW(VW), .DIW(DIW), .GW(GW), .GFRAC(GFRAC), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .vo_code_i(vo_code_i),
    .ref_code_i(ref_code_i), .incr_i(incr_i), .gain_i(gain_i),
    .err_o(err_o), .derr_o(derr_o), .duty_o(duty_o)
  );

  typedef struct {
    int    e;
    int    ce;
    int    d;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  int   m_prev_e = 0, m_duty = 0;
  logic v_d = 1'b0;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: model the step, push expectation, drive one strobe
  task automatic sample(int vo, int rf, int inc, int g, string tag);
    exp_t x;
    int   e, p, s;
    e = vo - rf;
    x.e = e;
    x.ce = e - m_prev_e;
    m_prev_e = e;
    p = inc * g;
    s = p >>> GFRAC;
    m_duty = m_duty + s;
    if (m_duty > FULL) m_duty = FULL;
    if (m_duty < 0)    m_duty = 0;
    x.d = m_duty;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    vo_code_i  = vo[VW-1:0];
    ref_code_i = rf[VW-1:0];
    incr_i     = inc[DIW-1:0];
    gain_i     = g[GW-1:0];
    sample_i   = 1'b1;
    @(negedge clk);
    sample_i   = 1'b0;
    @(negedge clk);
  endtask

  // monitor: outputs due one cycle after the strobe edge
  always @(posedge clk) v_d <= sample_i;

  always @(negedge clk) begin
    if (v_d) begin
      if (q.size() == 0) begin
        check("R2 queue", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check({"R2 err ", x.tag}, int'(err_o), x.e);
        check({"R3 derr ", x.tag}, int'(derr_o), x.ce);
        check({x.tag, " duty"}, int'(duty_o), x.d);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    m_prev_e = 0;
    m_duty = 0;
    @(negedge clk);
    check("R1 err", int'(err_o), 0);
    check("R1 derr", int'(derr_o), 0);
    check("R1 duty", int'(duty_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int he, hc, hd;
    #1;
    do_reset();
    sample(2100, 2000, 0, 16, "R3 first");
    sample(1900, 2000, 20, 16, "R5 unity");
    // R4: idle holding
    he = int'(err_o); hc = int'(derr_o); hd = int'(duty_o);
    sample_i = 1'b0;
    incr_i = 10'sd300; gain_i = 8'd200; vo_code_i = 12'd5; ref_code_i = 12'd999;
    repeat (5) @(negedge clk);
    check("R4 err", int'(err_o), he);
    check("R4 derr", int'(derr_o), hc);
    check("R4 duty", int'(duty_o), hd);
    sample(2000, 2000, 300, 0, "R8 zero gain");
    sample(2000, 2000, -3, 24, "R5 floor");
    sample(2050, 2000, 7, 40, "R5 frac");
    sample(4095, 0, 511, 255, "R6 top");
    sample(4095, 0, 511, 255, "R6 hold top");
    sample(0, 4095, -512, 255, "R7 bottom");
    sample(0, 4095, -1, 1, "R7 hold bottom");
    sample(1234, 1234, 100, 16, "R5 rise");
    do_reset();
    sample(1500, 2500, 50, 32, "R3 after reset");
    repeat (3) @(negedge clk);
    check("R2 queue drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule